// File: doc/BRIEF.md
# Tuning Command Receiver

This block is a write-only I2C slave for the synthesizer half of a tuner controller. It samples the bus clock and data lines with the system clock and finds start and stop conditions. It shifts in bytes and acknowledges them by enabling an open-drain pull on the data line.

When the address byte matches, the data bytes that follow are handled in pairs. The top bit of the leading byte of each pair selects the destination. One destination is a 15-bit frequency division word. The other is a control word plus four band switch bits. Each destination is a latched register output with a one-cycle load strobe.

Every start condition on the bus also raises a one-cycle transfer request, whatever address follows. The divider uses this pulse to move the pending ratio into its counter.

Top module: `tune_cmd_rx`

## Requirements
- R1: The address byte is acknowledged only when it equals `1100`, then `addrSel[1]`, `addrSel[0]`, then `0`, `0` (MSB first). With `addrSel`=0..3 this gives 0xC0, 0xC4, 0xC8 and 0xCC. Any other address byte, including one with the read bit set, gets no acknowledge, and the rest of the transfer has no effect.
- R2: A data pair whose leading byte has bit 7 = 0 is a frequency pair. After the second byte, `freqWord` becomes {leading byte bits 6..0, second byte} and `freqLoad` pulses.
- R3: A data pair whose leading byte has bit 7 = 1 is a control pair. `ctrlWord` takes bits 6..0 of the leading byte. `bandBits[3:0]` takes bits 7, 5, 3 and 1 of the second byte, in that order from MSB to LSB. `ctrlLoad` pulses.
- R4: Load strobes fire only on completion of the 2nd and the 4th data byte. Each strobe lasts one cycle, and the two strobes never fire together.
- R5: A 3rd data byte that has no 4th byte after it changes no output.
- R6: Data bytes after the 4th get no acknowledge and change no output.
- R7: Every start condition, including a repeated start and one before a foreign address, gives exactly one single-cycle `xferReq` pulse.
- R8: A start or stop condition inside a byte abandons that byte. No partial pair is loaded.
- R9: After reset: `freqWord` = 256, `ctrlWord` = 0, `bandBits` = 0, `sdaPullEn` = 0, and the receiver is idle.
- R10: An acknowledge asserts `sdaPullEn` after the SCL falling edge that follows the 8th bit. It is released after the next SCL falling edge, and it is never asserted while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| addrSel | input | 2 | Selects which of the four write addresses the block answers |
| sdaPullEn | output | 1 | Enables the open-drain pull-down on the data line |
| xferReq | output | 1 | One-cycle pulse on each start condition |
| freqWord | output | 15 | Latched division ratio |
| freqLoad | output | 1 | One-cycle strobe when `freqWord` is loaded |
| ctrlWord | output | 7 | Latched control bits |
| bandBits | output | 4 | Latched band switch bits |
| ctrlLoad | output | 1 | One-cycle strobe when `ctrlWord` and `bandBits` are loaded |

## Verification
The hardest case to reach is a transfer broken inside a byte after a pair has already been half staged. The leading byte has been kept internally, but nothing visible at the ports shows this. The bench creates the case by clocking out only a few bits of the second byte and then issuing a stop, or a repeated start. It then checks that no strobe fired and that a fresh pair after the restart loads correctly. Transfers of three and of five data bytes are driven so that the discarded trailing byte and the unacknowledged surplus byte can both be observed on the outputs.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACKWAIT,
    ST_ACK,
    ST_IGNORE
  } bus_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;   // take one bit into the shift register
    logic bitVal;  // value of that bit
    logic stage;   // completed byte is the leading byte of a pair
    logic commit;  // completed byte closes a pair: load outputs
  } strobe_t;

endpackage

// File: rtl/tcr_bus_ctrl.sv
module tcr_bus_ctrl
  import tcr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MAX_DATA = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    addrHit,
  output strobe_t strb,
  output logic    sdaPullEn,
  output logic    xferReq
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam int CNT_W = $clog2(MAX_DATA + 1);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  bus_state_t       state;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] dataCnt;
  logic             isAddr;
  logic             lastBit, dataRoom;

  // two-flop synchronizers, idle bus reads high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS     = sclSync[1];
  assign sdaS     = sdaSync[1];
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  assign lastBit  = (bitCnt == BIT_W'(DATA_W - 1));
  assign dataRoom = (dataCnt < CNT_W'(MAX_DATA));

  always_comb begin
    strb        = '0;
    strb.bitVal = sdaS;
    strb.shift  = (state == ST_SHIFT) && sclRise;
    if (strb.shift && lastBit && !isAddr && dataRoom) begin
      strb.stage  = ~dataCnt[0];
      strb.commit = dataCnt[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      dataCnt   <= '0;
      isAddr    <= 1'b0;
      sdaPullEn <= 1'b0;
      xferReq   <= 1'b0;
    end else begin
      xferReq <= startDet;
      if (startDet) begin
        state     <= ST_SHIFT;
        bitCnt    <= '0;
        dataCnt   <= '0;
        isAddr    <= 1'b1;
        sdaPullEn <= 1'b0;
      end else if (stopDet) begin
        state     <= ST_IDLE;
        sdaPullEn <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (lastBit) begin
              bitCnt <= '0;
              isAddr <= 1'b0;
              if (isAddr) begin
                state <= addrHit ? ST_ACKWAIT : ST_IGNORE;
              end else if (dataRoom) begin
                dataCnt <= dataCnt + 1'b1;
                state   <= ST_ACKWAIT;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_ACKWAIT: if (sclFall) begin
            state     <= ST_ACK;
            sdaPullEn <= 1'b1;
          end
          ST_ACK: if (sclFall) begin
            state     <= ST_SHIFT;
            sdaPullEn <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  assert_ack_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullEn) |-> !sclS);

  assert_xfer_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |=> !xferReq);

  assert_data_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    dataCnt <= CNT_W'(MAX_DATA));

endmodule

// File: rtl/tcr_datapath.sv
module tcr_datapath
  import tcr_pkg::*;
#(
  parameter int           DATA_W   = 8,
  parameter int           SEL_W    = 2,
  parameter logic [3:0]   ADDR_TOP = 4'b1100,
  parameter int           FREQ_RST = 256
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [SEL_W-1:0]      addrSel,
  output logic                  addrHit,
  output logic [2*DATA_W-2:0]   freqWord,
  output logic                  freqLoad,
  output logic [DATA_W-2:0]     ctrlWord,
  output logic [DATA_W/2-1:0]   bandBits,
  output logic                  ctrlLoad
);

  localparam int FREQ_W = 2 * DATA_W - 1;
  localparam int CTRL_W = DATA_W - 1;
  localparam int BAND_N = DATA_W / 2;
  localparam int LOW_W  = DATA_W - 4 - SEL_W;

  logic [DATA_W-2:0] shiftReg;
  logic [DATA_W-1:0] nextByte, stageByte;
  logic [BAND_N-1:0] bandNext;

  assign nextByte = {shiftReg, strb.bitVal};

  // address: fixed top nibble, pin-selected bits, then zeros (section bit, write)
  assign addrHit = (nextByte[DATA_W-1 -: 4] == ADDR_TOP) &&
                   (nextByte[LOW_W +: SEL_W] == addrSel) &&
                   (nextByte[LOW_W-1:0] == '0);

  for (genvar i = 0; i < BAND_N; i++) begin : gBand
    assign bandNext[i] = nextByte[2*i+1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      stageByte <= '0;
      freqWord  <= FREQ_W'(FREQ_RST);
      ctrlWord  <= '0;
      bandBits  <= '0;
      freqLoad  <= 1'b0;
      ctrlLoad  <= 1'b0;
    end else begin
      freqLoad <= 1'b0;
      ctrlLoad <= 1'b0;
      if (strb.shift) shiftReg <= nextByte[DATA_W-2:0];
      if (strb.stage) stageByte <= nextByte;
      if (strb.commit) begin
        if (!stageByte[DATA_W-1]) begin
          freqWord <= {stageByte[CTRL_W-1:0], nextByte};
          freqLoad <= 1'b1;
        end else begin
          ctrlWord <= stageByte[CTRL_W-1:0];
          bandBits <= bandNext;
          ctrlLoad <= 1'b1;
        end
      end
    end
  end

  assert_load_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(freqLoad && ctrlLoad));

  assert_load_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    (freqLoad || ctrlLoad) |=> !(freqLoad || ctrlLoad));

  assert_freq_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqWord) |-> freqLoad);

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(ctrlWord) || !$stable(bandBits)) |-> ctrlLoad);

endmodule

// File: rtl/tune_cmd_rx.sv
module tune_cmd_rx
  import tcr_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEL_W    = 2,
  parameter int MAX_DATA = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  input  logic [SEL_W-1:0]      addrSel,
  output logic                  sdaPullEn,
  output logic                  xferReq,
  output logic [2*DATA_W-2:0]   freqWord,
  output logic                  freqLoad,
  output logic [DATA_W-2:0]     ctrlWord,
  output logic [DATA_W/2-1:0]   bandBits,
  output logic                  ctrlLoad
);

  strobe_t strb;
  logic    addrHit;

  tcr_bus_ctrl #(.DATA_W(DATA_W), .MAX_DATA(MAX_DATA)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .strb(strb), .sdaPullEn(sdaPullEn), .xferReq(xferReq)
  );

  tcr_datapath #(.DATA_W(DATA_W), .SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addrSel(addrSel), .addrHit(addrHit),
    .freqWord(freqWord), .freqLoad(freqLoad), .ctrlWord(ctrlWord),
    .bandBits(bandBits), .ctrlLoad(ctrlLoad)
  );

endmodule

// File: tb/tune_cmd_rx_test.sv
`timescale 1ns/1ps
module tune_cmd_rx_test;

  localparam int HALF = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic [1:0] addrSel = 2'd2;
  logic sdaPullEn, xferReq, freqLoad, ctrlLoad;
  logic [14:0] freqWord;
  logic [6:0] ctrlWord;
  logic [3:0] bandBits;
  logic sdaLine;

  int checks = 0, errors = 0;
  int freqPulses = 0, ctrlPulses = 0, xferPulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sdaLine = sdaDrv & ~sdaPullEn;

  tune_cmd_rx uut (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaPullEn(sdaPullEn), .xferReq(xferReq), .freqWord(freqWord),
    .freqLoad(freqLoad), .ctrlWord(ctrlWord), .bandBits(bandBits),
    .ctrlLoad(ctrlLoad)
  );

  always @(posedge clk) begin
    if (freqLoad) freqPulses++;
    if (ctrlLoad) ctrlPulses++;
    if (xferReq)  xferPulses++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic waitH();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitH();
    sclDrv = 1'b1; waitH();
    sdaDrv = 1'b0; waitH();
    sclDrv = 1'b0; waitH();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitH();
    sclDrv = 1'b1; waitH();
    sdaDrv = 1'b1; waitH();
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaDrv = b[i]; waitH();
      sclDrv = 1'b1; waitH();
      sclDrv = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic sendByte(logic [7:0] b, output bit ack);
    sendBits(b, 8);
    sdaDrv = 1'b1; waitH();
    sclDrv = 1'b1; repeat (HALF/2) @(negedge clk);
    ack = !sdaLine;
    repeat (HALF/2) @(negedge clk);
    sclDrv = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    check("R9 freqWord", freqWord, 256);
    check("R9 ctrlWord", ctrlWord, 0);
    check("R9 bandBits", bandBits, 0);
    check("R9 sdaPullEn", sdaPullEn, 0);
  endtask

  task automatic testFreqPair();
    bit a0, a1, a2;
    int f0 = freqPulses, c0 = ctrlPulses, x0 = xferPulses;
    addrSel = 2'd2;
    busStart();
    sendByte(8'hC8, a0); sendByte(8'h12, a1); sendByte(8'h34, a2);
    busStop(); repeat (8) @(negedge clk);
    check("R1 ack address 0xC8", a0, 1);
    check("R10 ack data bytes", a1 & a2, 1);
    check("R2 freqWord", freqWord, 15'h1234);
    check("R2 freqLoad count", freqPulses - f0, 1);
    check("R2 no ctrlLoad", ctrlPulses - c0, 0);
    check("R7 one xferReq", xferPulses - x0, 1);
    check("R10 pull released", sdaPullEn, 0);
  endtask

  task automatic testCtrlPair();
    bit a;
    int c0 = ctrlPulses;
    busStart();
    sendByte(8'hC8, a); sendByte(8'hD5, a); sendByte(8'h82, a);
    busStop(); repeat (8) @(negedge clk);
    check("R3 ctrlWord", ctrlWord, 7'h55);
    check("R3 bandBits", bandBits, 4'b1001);
    check("R3 ctrlLoad count", ctrlPulses - c0, 1);
    check("R3 freq kept", freqWord, 15'h1234);
  endtask

  task automatic testFourBytes();
    bit a;
    int f0 = freqPulses, c0 = ctrlPulses;
    busStart();
    sendByte(8'hC8, a);
    sendByte(8'h7F, a);
    check("R4 no load after 1st byte", (freqPulses - f0) + (ctrlPulses - c0), 0);
    sendByte(8'hFF, a);
    check("R4 freq load after 2nd byte", freqPulses - f0, 1);
    sendByte(8'h80, a);
    check("R4 no load after 3rd byte", ctrlPulses - c0, 0);
    sendByte(8'h28, a);
    busStop(); repeat (8) @(negedge clk);
    check("R4 ctrl load after 4th byte", ctrlPulses - c0, 1);
    check("R4 freqWord max", freqWord, 15'h7FFF);
    check("R4 ctrlWord", ctrlWord, 0);
    check("R4 bandBits", bandBits, 4'b0110);
  endtask

  task automatic testThirdDropped();
    bit a;
    int f0 = freqPulses, c0 = ctrlPulses;
    busStart();
    sendByte(8'hC8, a); sendByte(8'h05, a); sendByte(8'h06, a);
    sendByte(8'h81, a);
    busStop(); repeat (8) @(negedge clk);
    check("R5 freqWord", freqWord, 15'h0506);
    check("R5 single freq load", freqPulses - f0, 1);
    check("R5 ctrl untouched", ctrlPulses - c0, 0);
    check("R5 bandBits kept", bandBits, 4'b0110);
  endtask

  task automatic testFifth();
    bit a, a5;
    int f0 = freqPulses, c0 = ctrlPulses;
    busStart();
    sendByte(8'hC8, a); sendByte(8'h01, a); sendByte(8'h23, a);
    sendByte(8'hC1, a); sendByte(8'h00, a);
    sendByte(8'h80, a5);
    sendByte(8'hAA, a);
    busStop(); repeat (8) @(negedge clk);
    check("R6 no ack 5th byte", a5, 0);
    check("R6 freqWord", freqWord, 15'h0123);
    check("R6 ctrlWord", ctrlWord, 7'h41);
    check("R6 bandBits", bandBits, 0);
    check("R6 loads", (freqPulses - f0) + (ctrlPulses - c0), 2);
  endtask

  task automatic testWrongAddr();
    bit a0, a1;
    int f0 = freqPulses, c0 = ctrlPulses, x0 = xferPulses;
    busStart();
    sendByte(8'hC0, a0); sendByte(8'h00, a1); sendByte(8'h00, a1);
    busStop();
    busStart();
    sendByte(8'hC9, a1); sendByte(8'h80, a1); sendByte(8'hFF, a1);
    busStop(); repeat (8) @(negedge clk);
    check("R1 no ack foreign address", a0, 0);
    check("R1 no ack read bit", a1, 0);
    check("R1 no loads", (freqPulses - f0) + (ctrlPulses - c0), 0);
    check("R1 freqWord kept", freqWord, 15'h0123);
    check("R7 xferReq on foreign starts", xferPulses - x0, 2);
  endtask

  task automatic testAbort();
    bit a;
    int f0 = freqPulses, c0 = ctrlPulses, x0 = xferPulses;
    busStart();
    sendByte(8'hC8, a); sendByte(8'h0A, a);
    sendBits(8'h0B, 4);
    busStop(); repeat (8) @(negedge clk);
    check("R8 stop mid byte no load", freqPulses - f0, 0);
    check("R8 freqWord kept", freqWord, 15'h0123);
    busStart();
    sendByte(8'hC8, a); sendByte(8'h8C, a);
    sendBits(8'hFF, 3);
    busStart();
    sendByte(8'hC8, a); sendByte(8'h0D, a); sendByte(8'h0E, a);
    busStop(); repeat (8) @(negedge clk);
    check("R8 start mid byte no ctrl load", ctrlPulses - c0, 0);
    check("R8 fresh pair after restart", freqWord, 15'h0D0E);
    check("R7 repeated start pulses", xferPulses - x0, 3);
  endtask

  task automatic testAddrSel();
    bit a;
    addrSel = 2'd0;
    busStart();
    sendByte(8'hC0, a); sendByte(8'h11, a); sendByte(8'h22, a);
    busStop(); repeat (8) @(negedge clk);
    check("R1 sel0 ack", a, 1);
    check("R1 sel0 freqWord", freqWord, 15'h1122);
    addrSel = 2'd3;
    busStart();
    sendByte(8'hC8, a);
    busStop();
    check("R1 sel3 rejects 0xC8", a, 0);
    busStart();
    sendByte(8'hCC, a); sendByte(8'hFF, a); sendByte(8'h20, a);
    busStop(); repeat (8) @(negedge clk);
    check("R1 sel3 ctrlWord", ctrlWord, 7'h7F);
    check("R1 sel3 bandBits", bandBits, 4'b0100);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testFreqPair();
    testCtrlPair();
    testFourBytes();
    testThirdDropped();
    testFifth();
    testWrongAddr();
    testAbort();
    testAddrSel();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule